// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block gathers five independent reasons to reset a chip and merges them into one system reset, synchronous to the clock. The five reasons are:

- a supply-good indication from a power monitor;
- an already synchronized, active-low external reset pin;
- an undervoltage comparator output with its own enable;
- a watchdog expiry pulse with its own enable;
- a reset bit held by a debug scan register.

Each reason has its own qualification rule:

- The pin must stay low for a minimum number of consecutive samples. A shorter glitch is dropped.
- The undervoltage and watchdog inputs count only while their enables are set.
- The debug bit holds reset for exactly as long as it stays at one.
- Supply-good low is treated as the block's own asynchronous reset. It asserts the system reset at once and releases it through a synchronizer.

Once every qualified reason has gone away, the system reset stays asserted for a fixed number of further cycles, then deasserts on a clock edge. A five-bit cause register records each reason that has fired since software last cleared it. Software clears bits by writing zeros to them. A power-up loss wipes every bit except the power bit.

Top module: `rstctl_top`

## Requirements
- R1: While `pwr_ok` is low, `sys_rst_n` is 0 and `cause` is 5'b00001. Both take these values asynchronously, without waiting for a clock edge, even in the middle of operation.
- R2: After `pwr_ok` rises between two edges, `sys_rst_n` goes high after rising edge number SYNC_STAGES+HOLD_CYCLES, counting from that rise. It is low after every earlier edge.
- R3: If `ext_rst_n` is sampled low on fewer than EXT_MIN consecutive rising edges, nothing happens. `sys_rst_n` stays 1 and `cause[1]` stays 0.
- R4: If `ext_rst_n` is sampled low on EXT_MIN consecutive edges, `sys_rst_n` goes low one edge after the last of those samples, and `cause[1]` (pin) is set. A single high sample restarts the count.
- R5: A `wdt_expire` pulse sampled while `wdt_en` is 1 drives `sys_rst_n` low for exactly HOLD_CYCLES cycles and sets `cause[3]` (watchdog). With `wdt_en` at 0 the pulse is ignored.
- R6: While `bod_trip` and `bod_en` are both 1, the system is held in reset and `cause[2]` (undervoltage) is set. With `bod_en` at 0 a trip is ignored.
- R7: While `dbg_rst` is 1, the system is held in reset and `cause[4]` (debug) is set.
- R8: `sys_rst_n` returns to 1 exactly HOLD_CYCLES edges after the last edge on which any qualified source was sampled active. Sources that overlap stretch the reset to cover their combined span.
- R9: When `cause_wr_en` is 1 on an edge, each cause bit whose `cause_wr_data` bit is 0 is cleared. Bits written with 1 are kept. A source that fires on the same edge sets its bit, and the set wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| pwr_ok | input | 1 | Supply-good indication; low means below the power-up threshold (asynchronous reset of the block) |
| ext_rst_n | input | 1 | Synchronized external reset pin, active low |
| bod_trip | input | 1 | Undervoltage comparator output, high when the supply is too low |
| bod_en | input | 1 | Enable for the undervoltage source |
| wdt_expire | input | 1 | Watchdog period-expired pulse |
| wdt_en | input | 1 | Enable for the watchdog source |
| dbg_rst | input | 1 | Reset bit from the debug scan register, active high |
| cause_wr_en | input | 1 | Software write strobe for the cause register |
| cause_wr_data | input | 5 | Write data; a 0 bit clears the matching cause bit |
| sys_rst_n | output | 1 | System reset, active low |
| cause | output | 5 | Cause flags: bit0 power, bit1 pin, bit2 undervoltage, bit3 watchdog, bit4 debug |

## Verification
The bench builds the controller with SYNC_STAGES=2, EXT_MIN=3 and HOLD_CYCLES=6. With a hold this short, many full reset windows fit into a few thousand random cycles. It also means a reset window often restarts in the middle of its countdown, or ends just as another source fires.

A pin threshold of three lets random pin toggling land on both sides of the acceptance point many times, including low runs of exactly two and exactly three samples.

// File: rtl/rstctl_pkg.sv
package rstctl_pkg;
  // Number of reset reasons and their bit positions in the cause register.
  localparam int unsigned SRC_N   = 5;
  localparam int unsigned SRC_PWR = 0;
  localparam int unsigned SRC_PIN = 1;
  localparam int unsigned SRC_BRN = 2;
  localparam int unsigned SRC_WDG = 3;
  localparam int unsigned SRC_DBG = 4;

  typedef logic [SRC_N-1:0] src_vec_t;
endpackage

// File: rtl/rstctl_sync.sv
// Asserts asynchronously on arst_n low; releases after STAGES clock edges.
module rstctl_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);
  logic [STAGES-1:0] sh_q;
  logic [STAGES-1:0] sh_d;

  always_comb begin
    sh_d = {sh_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sh_q <= '0;
    else         sh_q <= sh_d;
  end

  assign rst_n = sh_q[STAGES-1];
endmodule

// File: rtl/rstctl_pulse_filter.sv
// Qualifies an active-low pin once it has been sampled low MIN_LOW times in a row.
module rstctl_pulse_filter #(
  parameter int unsigned MIN_LOW = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin_n,
  output logic qual
);
  localparam int unsigned CW = $clog2(MIN_LOW + 1);
  localparam logic [CW-1:0] CNT_MAX = CW'(MIN_LOW);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = pin_n ? (cnt_q != '0) : (cnt_q != CNT_MAX);
    cnt_d  = pin_n ? '0 : cnt_q + CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign qual = (cnt_q == CNT_MAX);

  // R3: qualification only follows a low sample
  a_r3_qual_after_low: assert property (@(posedge clk) disable iff (!rst_n)
    qual |-> $past(!pin_n));
  // R4: one high sample restarts the filter
  a_r4_high_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    pin_n |=> !qual);
endmodule

// File: rtl/rstctl_stretch.sv
// Holds reset while req is high, then for HOLD further edges.
module rstctl_stretch #(
  parameter int unsigned HOLD = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic rst_act
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] CNT_LOAD = CW'(HOLD);

  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;
  logic          cnt_en;
  logic          rst_q;
  logic          rst_d;

  always_comb begin
    cnt_en = req | (cnt_q != '0);
    cnt_d  = req ? CNT_LOAD : cnt_q - CW'(1);
    rst_d  = req | (cnt_q > CW'(1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= CNT_LOAD;
      rst_q <= 1'b1;
    end else begin
      if (cnt_en) cnt_q <= cnt_d;
      rst_q <= rst_d;
    end
  end

  assign rst_act = rst_q;

  // R8: an active request asserts reset on the next edge
  a_r8_req_asserts: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> rst_act);
  // R8: reset only drops after a quiet edge
  a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rst_act) |-> $past(!req));
endmodule

// File: rtl/rstctl_cause.sv
// Sticky cause flags; software clears bits by writing zero, sets win.
module rstctl_cause
  import rstctl_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  src_vec_t set_vec,
  input  logic     wr_en,
  input  src_vec_t wr_data,
  output src_vec_t flags
);
  src_vec_t flag_q;
  src_vec_t flag_d;

  for (genvar i = 0; i < SRC_N; i++) begin : g_bit
    localparam logic RST_VAL = (i == SRC_PWR);

    always_comb begin
      flag_d[i] = set_vec[i] | (flag_q[i] & ~(wr_en & ~wr_data[i]));
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= RST_VAL;
      else        flag_q[i] <= flag_d[i];
    end

    // R9: a zero write clears the bit unless its source fires
    a_r9_clear_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_data[i] && !set_vec[i]) |=> !flags[i]);
    // R9: a firing source always leaves its bit set
    a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      set_vec[i] |=> flags[i]);
  end

  assign flags = flag_q;
endmodule

// File: rtl/rstctl_top.sv
module rstctl_top
  import rstctl_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned EXT_MIN     = 4,
  parameter int unsigned HOLD_CYCLES = 16
) (
  input  logic       clk,
  input  logic       pwr_ok,
  input  logic       ext_rst_n,
  input  logic       bod_trip,
  input  logic       bod_en,
  input  logic       wdt_expire,
  input  logic       wdt_en,
  input  logic       dbg_rst,
  input  logic       cause_wr_en,
  input  logic [4:0] cause_wr_data,
  output logic       sys_rst_n,
  output logic [4:0] cause
);
  logic     core_rst_n;
  logic     pin_qual;
  logic     any_src;
  logic     rst_act;
  src_vec_t src_vec;

  rstctl_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .arst_n (pwr_ok),
    .rst_n  (core_rst_n)
  );

  rstctl_pulse_filter #(.MIN_LOW(EXT_MIN)) u_filter (
    .clk   (clk),
    .rst_n (core_rst_n),
    .pin_n (ext_rst_n),
    .qual  (pin_qual)
  );

  always_comb begin
    src_vec          = '0;
    src_vec[SRC_PIN] = pin_qual;
    src_vec[SRC_BRN] = bod_trip & bod_en;
    src_vec[SRC_WDG] = wdt_expire & wdt_en;
    src_vec[SRC_DBG] = dbg_rst;
    any_src          = |src_vec;
  end

  rstctl_stretch #(.HOLD(HOLD_CYCLES)) u_stretch (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .req     (any_src),
    .rst_act (rst_act)
  );

  rstctl_cause u_cause (
    .clk     (clk),
    .rst_n   (core_rst_n),
    .set_vec (src_vec),
    .wr_en   (cause_wr_en),
    .wr_data (cause_wr_data),
    .flags   (cause)
  );

  assign sys_rst_n = ~rst_act;

  // R1: power loss forces reset and the power-only cause value
  always @(posedge clk) begin
    if (!pwr_ok) begin
      a_r1_por_state: assert (sys_rst_n == 1'b0 && cause == 5'b00001);
    end
  end

  // R5: an enabled watchdog expiry resets the system
  a_r5_wdg_fires: assert property (@(posedge clk) disable iff (!core_rst_n)
    (wdt_expire && wdt_en) |=> !sys_rst_n);
  // R6: an enabled undervoltage trip resets the system
  a_r6_brn_fires: assert property (@(posedge clk) disable iff (!core_rst_n)
    (bod_trip && bod_en) |=> !sys_rst_n);
  // R7: the debug bit holds reset
  a_r7_dbg_holds: assert property (@(posedge clk) disable iff (!core_rst_n)
    dbg_rst |=> (!sys_rst_n && cause[SRC_DBG]));
endmodule

// File: tb/rstctl_top_bench.sv
`timescale 1ns/1ps
module rstctl_top_bench;
  localparam int SYNC = 2;
  localparam int EMIN = 3;
  localparam int HOLD = 6;

  logic       clk = 1'b0;
  logic       pwr_ok = 1'b1;
  logic       ext_rst_n = 1'b1;
  logic       bod_trip = 1'b0;
  logic       bod_en = 1'b0;
  logic       wdt_expire = 1'b0;
  logic       wdt_en = 1'b0;
  logic       dbg_rst = 1'b0;
  logic       cause_wr_en = 1'b0;
  logic [4:0] cause_wr_data = 5'b0;
  logic       sys_rst_n;
  logic [4:0] cause;

  rstctl_top #(.SYNC_STAGES(SYNC), .EXT_MIN(EMIN), .HOLD_CYCLES(HOLD)) u_rstctl_top (
    .clk(clk), .pwr_ok(pwr_ok), .ext_rst_n(ext_rst_n), .bod_trip(bod_trip),
    .bod_en(bod_en), .wdt_expire(wdt_expire), .wdt_en(wdt_en), .dbg_rst(dbg_rst),
    .cause_wr_en(cause_wr_en), .cause_wr_data(cause_wr_data),
    .sys_rst_n(sys_rst_n), .cause(cause)
  );

  always #2 clk = ~clk;

  int         n_chk = 0;
  int         n_bad = 0;
  bit         done = 0;
  int         m_flt;
  int         m_hold;
  logic [4:0] m_cause;

  function automatic logic [4:0] next_cause(logic [4:0] cur, logic we,
                                            logic [4:0] wd, logic [4:0] setv);
    logic [4:0] r;
    r = we ? (cur & wd) : cur;
    return r | setv;
  endfunction

  function automatic int next_hold(int cur, bit active);
    if (active) return HOLD;
    return (cur > 0) ? cur - 1 : 0;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // One clock edge: update the expected model from the sampled inputs, then compare.
  task automatic tick(string tag);
    logic [4:0] s;
    @(posedge clk);
    s    = 5'b0;
    s[1] = (m_flt == EMIN);
    s[2] = bod_trip & bod_en;
    s[3] = wdt_expire & wdt_en;
    s[4] = dbg_rst;
    m_cause = next_cause(m_cause, cause_wr_en, cause_wr_data, s);
    m_hold  = next_hold(m_hold, s != 5'b0);
    m_flt   = ext_rst_n ? 0 : ((m_flt < EMIN) ? m_flt + 1 : m_flt);
    #1;
    check({tag, " reset"}, {31'b0, sys_rst_n}, {31'b0, m_hold == 0});
    check({tag, " cause"}, {27'b0, cause}, {27'b0, m_cause});
  endtask

  // Counts observed low cycles, starting with the current one.
  task automatic low_len(string tag, output int n);
    n = 0;
    while (sys_rst_n === 1'b0 && n < 500) begin
      n++;
      tick(tag);
    end
  endtask

  task automatic quiet_inputs();
    ext_rst_n = 1'b1; bod_trip = 1'b0; wdt_expire = 1'b0; dbg_rst = 1'b0;
    cause_wr_en = 1'b0;
  endtask

  task automatic power_cycle();
    int edges;
    quiet_inputs();
    @(negedge clk);
    pwr_ok = 1'b0;
    #0.5;
    check("R1 async reset", {31'b0, sys_rst_n}, 32'd0);
    check("R1 async cause", {27'b0, cause}, 32'd1);
    repeat (3) @(posedge clk);
    #1;
    check("R1 held reset", {31'b0, sys_rst_n}, 32'd0);
    @(negedge clk);
    pwr_ok = 1'b1;
    edges = 0;
    while (sys_rst_n !== 1'b1 && edges < 100) begin
      @(posedge clk);
      edges++;
      #1;
    end
    check("R2 release edge", edges, SYNC + HOLD);
    check("R1 cause after power", {27'b0, cause}, 32'd1);
    m_hold = 0; m_flt = 0; m_cause = 5'b00001;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int n;
    void'($urandom(32'h1d0c_5eed));
    #1;
    power_cycle();

    // R9: clear everything, keeping bits written with 1 (here only bit1, which is 0)
    cause_wr_en = 1'b1; cause_wr_data = 5'b00010;
    tick("R9 clear");
    cause_wr_en = 1'b0;
    check("R9 cleared", {27'b0, cause}, 32'd0);

    // R3: low run one sample short of the threshold is ignored
    ext_rst_n = 1'b0;
    repeat (EMIN - 1) tick("R3 short low");
    ext_rst_n = 1'b1;
    repeat (8) tick("R3 after short");
    check("R3 no reset", {31'b0, sys_rst_n}, 32'd1);
    check("R3 no pin flag", {31'b0, cause[1]}, 32'd0);

    // R4: low run of exactly the threshold is accepted
    ext_rst_n = 1'b0;
    repeat (EMIN) tick("R4 low");
    ext_rst_n = 1'b1;
    check("R4 not yet", {31'b0, sys_rst_n}, 32'd1);
    tick("R4 accept");
    check("R4 asserted", {31'b0, sys_rst_n}, 32'd0);
    low_len("R4 window", n);
    check("R4 window length", n, HOLD);
    check("R4 pin flag", {27'b0, cause}, 32'b00010);

    // R5: watchdog ignored when disabled, then fires when enabled
    wdt_en = 1'b0; wdt_expire = 1'b1;
    tick("R5 disabled");
    wdt_expire = 1'b0;
    repeat (3) tick("R5 disabled after");
    check("R5 disabled no reset", {31'b0, sys_rst_n}, 32'd1);
    check("R5 disabled no flag", {31'b0, cause[3]}, 32'd0);
    wdt_en = 1'b1; wdt_expire = 1'b1;
    tick("R5 enabled");
    wdt_expire = 1'b0;
    low_len("R5 window", n);
    check("R5 window length", n, HOLD);
    check("R5 flag", {31'b0, cause[3]}, 32'd1);

    // R6: undervoltage ignored when disabled, held when enabled
    cause_wr_en = 1'b1; cause_wr_data = 5'b0;
    tick("R6 clear");
    cause_wr_en = 1'b0;
    bod_en = 1'b0; bod_trip = 1'b1;
    repeat (4) tick("R6 disabled");
    check("R6 disabled no reset", {31'b0, sys_rst_n}, 32'd1);
    bod_en = 1'b1;
    repeat (5) tick("R6 held");
    check("R6 held reset", {31'b0, sys_rst_n}, 32'd0);
    bod_trip = 1'b0;
    low_len("R6 release", n);
    check("R6 release length", n, HOLD);
    check("R6 flag", {27'b0, cause}, 32'b00100);

    // R7: debug bit holds reset for its whole duration
    dbg_rst = 1'b1;
    repeat (20) tick("R7 held");
    check("R7 still low", {31'b0, sys_rst_n}, 32'd0);
    dbg_rst = 1'b0;
    low_len("R7 release", n);
    check("R7 release length", n, HOLD);
    check("R7 flag", {31'b0, cause[4]}, 32'd1);

    // R9: set on the same edge as a zero write wins
    cause_wr_en = 1'b1; cause_wr_data = 5'b0; wdt_expire = 1'b1;
    tick("R9 set wins");
    cause_wr_en = 1'b0; wdt_expire = 1'b0;
    check("R9 set wins value", {27'b0, cause}, 32'b01000);
    low_len("R9 drain", n);

    // R8: overlapping sources extend the window to the last one
    wdt_expire = 1'b1;
    tick("R8 wdg");
    wdt_expire = 1'b0;
    repeat (3) tick("R8 countdown");
    dbg_rst = 1'b1;
    repeat (3) tick("R8 dbg");
    bod_trip = 1'b1;
    tick("R8 both");
    dbg_rst = 1'b0;
    tick("R8 brn only");
    bod_trip = 1'b0;
    low_len("R8 tail", n);
    check("R8 tail length", n, HOLD);
    check("R8 flags", {27'b0, cause}, 32'b11100);

    // R1: power loss in the middle of a debug reset
    dbg_rst = 1'b1;
    repeat (2) tick("R1 pre");
    power_cycle();

    // R8 R9: constrained random traffic against the expected model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom % 5 == 0) ext_rst_n = ~ext_rst_n;
      if ($urandom % 60 == 0) bod_trip = ~bod_trip;
      if ($urandom % 100 == 0) bod_en = ~bod_en;
      wdt_expire    = ($urandom % 40 == 0);
      wdt_en        = ($urandom % 4 != 0);
      if ($urandom % 90 == 0) dbg_rst = ~dbg_rst;
      cause_wr_en   = ($urandom % 6 == 0);
      cause_wr_data = 5'($urandom);
      tick("R8 R9 random");
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule